// File: doc/BRIEF.md
# CBR Refresh and Power-Up Controller

This block brings a fast page mode DRAM out of power-up and then keeps its contents alive. It uses refresh cycles in which the column strobe falls before the row strobe. In that ordering the memory takes the row from its own internal counter, so the block never drives an address. After reset it counts clock cycles for a 200 µs quiet period. It then runs eight such refresh cycles back to back and raises `init_done`. From then on it schedules one refresh per fixed interval. The interval is 8 ms divided over 512 rows for the standard part, or 64 ms over 512 rows for the low-power part, chosen by a parameter.

The block shares the DRAM strobes with an access sequencer through a request/grant pair. It raises `ref_req` and holds it until `ref_gnt` arrives. It then drives the row and column strobes itself for the whole cycle, including the precharge tail, and drops the request in the first cycle after precharge ends. If the sequencer keeps the bus busy, interval ticks pile up as owed refreshes. The owed refreshes are served back to back once the grant returns. `ref_urgent` is raised while more than eight are owed. All cycle counts come from a clock-period parameter. Minimum pulse widths are rounded up and the refresh interval is rounded down.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: After reset release the block keeps `ref_req` low and both strobes high for at least ceil(200 µs / clock period) cycles (40000 at 5 ns), with `init_done` and `ref_urgent` low. The first column-strobe fall comes no more than 4 cycles after that count.
- R2: After the pause exactly 8 refresh cycles are completed before `init_done` goes high, and `init_done` then stays high until reset.
- R3: In each refresh cycle the column strobe goes low ceil(5 ns / period) cycles (1 at 5 ns) before the row strobe falls. It stays low for ceil(15 ns / period) cycles (3 at 5 ns) of the row-low time, then returns high while the row strobe is still low.
- R4: The row strobe stays low for ceil(60 ns / period) cycles (12 at 5 ns).
- R5: After the row strobe rises, both strobes stay high with `ref_req` still high for max(ceil(40 ns / period), ceil(110 ns / period) - row-low cycles) cycles (10 at 5 ns). `ref_req` falls in the next cycle.
- R6: With prompt grants, successive row-strobe falls after initialisation are floor(8 ms / 512 / period) cycles apart (3125 at 5 ns) when `LOW_POWER` is 0, and floor(64 ms / 512 / period) cycles apart (25000) when it is 1.
- R7: `ref_req`, once raised, stays high until the cycle it serves completes. No strobe moves while `ref_gnt` is withheld.
- R8: Interval ticks that cannot be served are counted as owed. `ref_urgent` is high exactly while more than 8 are owed. On grant, the owed refreshes run back to back until none remain, and `ref_urgent` then falls.
- R9: `dram_we_n` is high at all times, including reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose period is `CLK_PS` |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer, held while `ref_req` is high |
| ref_req | output | 1 | Refresh ownership request, held through the whole cycle |
| dram_ras_n | output | 1 | Row strobe to the DRAM, active low |
| dram_cas_n | output | 1 | Column strobe to the DRAM, active low |
| dram_we_n | output | 1 | Write enable to the DRAM, kept high |
| init_done | output | 1 | Power-up pause and eight start-up refreshes finished |
| ref_urgent | output | 1 | More than eight refreshes owed |

## Verification
The assertions assume the sequencer asserts `ref_gnt` only while `ref_req` is high and keeps it high until `ref_req` drops. They also assume the real clock period equals `CLK_PS`. The bench's grant responder follows both rules: it grants one cycle after seeing a request and withdraws the grant only as the request falls. During the busy-bus phase it holds the grant off completely, so no cycle is ever interrupted once started. The withholding window starts right after a completed refresh, which makes the number of owed refreshes at each checkpoint exact.

// File: rtl/cbr_rfc_pkg.sv
package cbr_rfc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_REQ    = 3'd1,
    PH_LEAD   = 3'd2,
    PH_STROBE = 3'd3,
    PH_PRECH  = 3'd4
  } phase_e;

  // Width needed to hold values 0..n-1 (at least one bit).
  function automatic int unsigned bits_for(input longint unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Minimum-duration conversion: never shorter than asked.
  function automatic int unsigned cyc_ceil(input longint unsigned t_ps,
                                           input longint unsigned clk_ps);
    return int'((t_ps + clk_ps - 1) / clk_ps);
  endfunction

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cyc_rest(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  // Refresh spacing: window spread over all rows, rounded down so it is never late.
  function automatic int unsigned gap_cycles(input longint unsigned window_ns,
                                             input longint unsigned rows,
                                             input longint unsigned clk_ps);
    return int'((window_ns * 1000) / (rows * clk_ps));
  endfunction

endpackage

// File: rtl/cbr_rfc_timebase.sv
module cbr_rfc_timebase
  import cbr_rfc_pkg::*;
#(
  parameter int unsigned N_PAUSE = 40000,
  parameter int unsigned N_INT   = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_int,
  output logic pause_done,
  output logic tick
);
  localparam int unsigned PW = bits_for(N_PAUSE);
  localparam int unsigned IW = bits_for(N_INT);

  logic [PW-1:0] pause_cnt_q;
  logic          pause_over_q;
  logic [IW-1:0] int_cnt_q;

  assign pause_done = !pause_over_q && (pause_cnt_q == PW'(N_PAUSE - 1));
  assign tick       = run_int && (int_cnt_q == IW'(N_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt_q  <= '0;
      pause_over_q <= 1'b0;
    end else if (!pause_over_q) begin
      if (pause_done) pause_over_q <= 1'b1;
      else            pause_cnt_q  <= pause_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_int) int_cnt_q <= '0;
    else if (tick)          int_cnt_q <= '0;
    else                    int_cnt_q <= int_cnt_q + 1'b1;
  end

  AST_TICK_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pause_over_q);  // R6
  AST_PAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> !pause_done);  // R1

endmodule

// File: rtl/cbr_rfc_debt.sv
module cbr_rfc_debt
  import cbr_rfc_pkg::*;
#(
  parameter int unsigned INIT_N       = 8,
  parameter int unsigned URGENT_LIMIT = 8,
  parameter int unsigned MAX_OWED     = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_init,
  input  logic tick,
  input  logic served,
  output logic owed_nz,
  output logic init_done,
  output logic urgent
);
  localparam int unsigned OW = bits_for(MAX_OWED + 1);

  logic [OW-1:0] owed_q;
  logic          loaded_q;
  logic          init_done_q;
  logic          grow, shrink;

  assign grow   = tick && !served && (owed_q != OW'(MAX_OWED));
  assign shrink = served && !tick && (owed_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q      <= '0;
      loaded_q    <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      if (load_init) begin
        owed_q   <= OW'(INIT_N);
        loaded_q <= 1'b1;
      end else if (grow) begin
        owed_q <= owed_q + 1'b1;
      end else if (shrink) begin
        owed_q <= owed_q - 1'b1;
      end
      if (loaded_q && (owed_q == '0)) init_done_q <= 1'b1;
    end
  end

  assign owed_nz   = (owed_q != '0);
  assign init_done = init_done_q;
  assign urgent    = (owed_q > OW'(URGENT_LIMIT));

  AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_init) |-> (owed_q == $past(owed_q) || owed_q == $past(owed_q) + 1'b1 ||
                           owed_q == $past(owed_q) - 1'b1));  // R8
  AST_SERVE_HAS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> (owed_q != '0));  // R8
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_q |=> init_done_q);  // R2

endmodule

// File: rtl/cbr_rfc_cycle.sv
module cbr_rfc_cycle
  import cbr_rfc_pkg::*;
#(
  parameter int unsigned N_CSR = 1,
  parameter int unsigned N_CHR = 3,
  parameter int unsigned N_RAS = 12,
  parameter int unsigned N_RP  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic gnt,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic served
);
  localparam int unsigned MAXC = cyc_max(cyc_max(N_CSR, N_RAS), N_RP);
  localparam int unsigned CW   = bits_for(MAXC + 1);
  localparam int unsigned RW   = bits_for(4 * MAXC + 2);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          req_q, ras_q, cas_q;
  logic          cnt_zero;
  logic [CW-1:0] ras_elapsed;

  assign cnt_zero    = (cnt_q == '0);
  assign served      = (phase_q == PH_PRECH) && cnt_zero;
  assign ras_elapsed = CW'(N_RAS) - cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (want) begin
            phase_q <= PH_REQ;
            req_q   <= 1'b1;
          end
        end
        PH_REQ: begin
          if (gnt) begin
            phase_q <= PH_LEAD;
            cas_q   <= 1'b0;
            cnt_q   <= CW'(N_CSR - 1);
          end
        end
        PH_LEAD: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            ras_q   <= 1'b0;
            cnt_q   <= CW'(N_RAS - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            phase_q <= PH_PRECH;
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
            cnt_q   <= CW'(N_RP - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
            cas_q <= (ras_elapsed >= CW'(N_CHR));
          end
        end
        PH_PRECH: begin
          if (cnt_zero) begin
            phase_q <= PH_IDLE;
            req_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req   = req_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;

  // Run-length counters used only by the checks below.
  logic [RW-1:0] lo_run_q, hi_run_q, chr_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run_q  <= '0;
      hi_run_q  <= '0;
      chr_run_q <= '0;
    end else begin
      lo_run_q  <= ras_q ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q  <= !ras_q ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
      chr_run_q <= (ras_q || cas_q) ? '0 : ((chr_run_q == '1) ? chr_run_q : chr_run_q + 1'b1);
    end
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> (!cas_q && !$past(cas_q)));  // R3
  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_q) && !ras_q) |-> (chr_run_q >= RW'(N_CHR)));  // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_q) |-> (lo_run_q >= RW'(N_RAS)));  // R4
  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_q) && ras_q) |-> (hi_run_q >= RW'(N_RP)));  // R5
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_q || !cas_q) |-> req_q);  // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !served) |=> req_q);  // R7

endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_rfc_pkg::*;
#(
  parameter int unsigned CLK_PS         = 5000,
  parameter bit          LOW_POWER      = 1'b0,
  parameter int unsigned STARTUP_NS     = 200_000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned URGENT_LIMIT   = 8,
  parameter int unsigned MAX_OWED       = 31,
  parameter int unsigned ROWS           = 512,
  parameter int unsigned WINDOW_NS      = 8_000_000,
  parameter int unsigned WINDOW_LP_NS   = 64_000_000,
  parameter int unsigned T_CSR_PS       = 5_000,
  parameter int unsigned T_CHR_PS       = 15_000,
  parameter int unsigned T_RAS_PS       = 60_000,
  parameter int unsigned T_RC_PS        = 110_000,
  parameter int unsigned T_RP_PS        = 40_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n,
  output logic init_done,
  output logic ref_urgent
);
  localparam int unsigned N_PAUSE = cyc_ceil(longint'(STARTUP_NS) * 1000, CLK_PS);
  localparam int unsigned WIN_SEL = LOW_POWER ? WINDOW_LP_NS : WINDOW_NS;
  localparam int unsigned N_INT   = gap_cycles(WIN_SEL, ROWS, CLK_PS);
  localparam int unsigned N_CSR   = cyc_max(1, cyc_ceil(T_CSR_PS, CLK_PS));
  localparam int unsigned N_CHR   = cyc_max(1, cyc_ceil(T_CHR_PS, CLK_PS));
  localparam int unsigned N_RAS   = cyc_max(cyc_ceil(T_RAS_PS, CLK_PS), N_CHR);
  localparam int unsigned N_RP    = cyc_max(1, cyc_max(cyc_ceil(T_RP_PS, CLK_PS),
                                           cyc_rest(cyc_ceil(T_RC_PS, CLK_PS), N_RAS)));

  logic pause_done, tick, served, owed_nz, init_done_w;

  cbr_rfc_timebase #(
    .N_PAUSE (N_PAUSE),
    .N_INT   (N_INT)
  ) timebase_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_int    (init_done_w),
    .pause_done (pause_done),
    .tick       (tick)
  );

  cbr_rfc_debt #(
    .INIT_N       (INIT_REFRESHES),
    .URGENT_LIMIT (URGENT_LIMIT),
    .MAX_OWED     (MAX_OWED)
  ) debt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_init (pause_done),
    .tick      (tick),
    .served    (served),
    .owed_nz   (owed_nz),
    .init_done (init_done_w),
    .urgent    (ref_urgent)
  );

  cbr_rfc_cycle #(
    .N_CSR (N_CSR),
    .N_CHR (N_CHR),
    .N_RAS (N_RAS),
    .N_RP  (N_RP)
  ) cycle_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (owed_nz),
    .gnt    (ref_gnt),
    .req    (ref_req),
    .ras_n  (dram_ras_n),
    .cas_n  (dram_cas_n),
    .served (served)
  );

  assign dram_we_n = 1'b1;
  assign init_done = init_done_w;

  AST_QUIET_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done_w && !owed_nz && !ref_req) |-> (dram_ras_n && dram_cas_n));  // R1
  AST_URGENT_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> init_done_w);  // R8

endmodule

// File: tb/cbr_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module cbr_refresh_ctrl_tb_top;
  localparam longint CLK_PS     = 5000;
  localparam longint EXP_PAUSE  = (200_000_000 + CLK_PS - 1) / CLK_PS;
  localparam longint EXP_LEAD   = (5_000 + CLK_PS - 1) / CLK_PS;
  localparam longint EXP_CHR    = (15_000 + CLK_PS - 1) / CLK_PS;
  localparam longint EXP_RAS    = (60_000 + CLK_PS - 1) / CLK_PS;
  localparam longint RP_MIN     = (40_000 + CLK_PS - 1) / CLK_PS;
  localparam longint RC_REST    = (110_000 + CLK_PS - 1) / CLK_PS - EXP_RAS;
  localparam longint EXP_PRE    = (RP_MIN > RC_REST) ? RP_MIN : RC_REST;
  localparam longint EXP_INT    = 64'd8_000_000_000 / 512 / CLK_PS;
  localparam longint EXP_INT_LP = 64'd64_000_000_000 / 512 / CLK_PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_gnt = 1'b0, gnt_lp = 1'b0, gnt_allow = 1'b1;
  logic ref_req, dram_ras_n, dram_cas_n, dram_we_n, init_done, ref_urgent;
  logic req_lp, ras_lp, cas_lp, we_lp, done_lp, urg_lp;

  always #2.5 clk = ~clk;

  cbr_refresh_ctrl #(.CLK_PS(5000), .LOW_POWER(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .init_done(init_done), .ref_urgent(ref_urgent));

  cbr_refresh_ctrl #(.CLK_PS(5000), .LOW_POWER(1'b1)) dut_lp_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt_lp), .ref_req(req_lp),
    .dram_ras_n(ras_lp), .dram_cas_n(cas_lp), .dram_we_n(we_lp),
    .init_done(done_lp), .ref_urgent(urg_lp));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Scoreboard: expected refresh shapes
  typedef struct {
    longint lead;
    longint rlow;
    longint chr;
    longint pre;
  } shape_t;
  shape_t exp_q[$];

  task automatic push_expected(input int n);
    shape_t s;
    s.lead = EXP_LEAD; s.rlow = EXP_RAS; s.chr = EXP_CHR; s.pre = EXP_PRE;
    for (int i = 0; i < n; i++) exp_q.push_back(s);
  endtask

  // Grant responders (sequencer model)
  always @(negedge clk) begin
    ref_gnt <= ref_req && gnt_allow;
    gnt_lp  <= req_lp;
  end

  longint cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Monitor
  longint m_lead = 0, m_rlow = 0, m_chr = 0, m_pre = 0;
  bit     m_post = 1'b0, prev_ras = 1'b1, lp_prev = 1'b1;
  int     n_done = 0, init_at = -1, we_bad = 0;
  longint first_cas = -1;
  longint falls[$];
  longint lp_falls[$];

  always @(negedge clk) begin
    if (dram_we_n !== 1'b1 || we_lp !== 1'b1) we_bad++;
    if (rst_n) begin
      if (!dram_cas_n && first_cas < 0) first_cas = cyc;
      if (!dram_ras_n && prev_ras) falls.push_back(cyc);
      if (!dram_cas_n && dram_ras_n && !m_post) m_lead++;
      if (!dram_ras_n) m_rlow++;
      if (!dram_ras_n && !dram_cas_n) m_chr++;
      if (dram_ras_n && m_rlow > 0) m_post = 1'b1;
      if (m_post && dram_ras_n && dram_cas_n && ref_req) m_pre++;
      if (m_post && !ref_req) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "refresh with no expected item", n_done, -1);
        end else begin
          shape_t e;
          e = exp_q.pop_front();
          check(m_lead == e.lead, "R3", "column lead cycles", m_lead, e.lead);
          check(m_chr == e.chr, "R3", "column hold cycles", m_chr, e.chr);
          check(m_rlow == e.rlow, "R4", "row low cycles", m_rlow, e.rlow);
          check(m_pre == e.pre, "R5", "precharge cycles under request", m_pre, e.pre);
        end
        n_done++;
        m_lead = 0; m_rlow = 0; m_chr = 0; m_pre = 0; m_post = 1'b0;
      end
      if (init_done && init_at < 0) init_at = n_done;
      prev_ras = dram_ras_n;
      if (!ras_lp && lp_prev) lp_falls.push_back(cyc);
      lp_prev = ras_lp;
    end
  end

  // Watchdog
  initial begin
    repeat (150_000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", cyc, 0);
    end_run();
  end

  initial begin
    longint s;
    int     done0;
    bit     pr;
    push_expected(40);
    repeat (4) @(negedge clk);
    #1;
    check(dram_ras_n == 1'b1 && dram_cas_n == 1'b1, "R1", "strobes high in reset",
          {dram_ras_n, dram_cas_n}, 3);
    check(ref_req == 1'b0 && init_done == 1'b0 && ref_urgent == 1'b0, "R1",
          "req/init_done/urgent low in reset", {ref_req, init_done, ref_urgent}, 0);
    check(dram_we_n == 1'b1, "R9", "write enable high in reset", dram_we_n, 1);
    @(negedge clk);
    rst_n = 1'b1;

    wait (cyc >= EXP_PAUSE - 2);
    @(negedge clk); #1;
    check(ref_req == 1'b0 && dram_cas_n == 1'b1 && dram_ras_n == 1'b1, "R1",
          "quiet near end of pause", {ref_req, dram_cas_n, dram_ras_n}, 3'b011);
    check(init_done == 1'b0, "R1", "init_done low during pause", init_done, 0);

    wait (first_cas >= 0); #1;
    check(first_cas >= EXP_PAUSE && first_cas <= EXP_PAUSE + 4, "R1",
          "first column strobe cycle", first_cas, EXP_PAUSE);

    wait (init_done == 1'b1);
    @(negedge clk); #1;
    check(init_at == 8, "R2", "refreshes done when init_done rose", init_at, 8);

    wait (falls.size() >= 12); #1;
    for (int i = 9; i < 12; i++)
      check(falls[i] - falls[i-1] == EXP_INT, "R6", "standard refresh spacing",
            falls[i] - falls[i-1], EXP_INT);

    // Busy bus: start right after a completed refresh
    pr = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (pr && !ref_req) break;
      pr = ref_req;
    end
    s = cyc;
    gnt_allow = 1'b0;
    done0 = n_done;

    wait (cyc >= s + (17 * EXP_INT) / 2);
    @(negedge clk); #1;
    check(ref_urgent == 1'b0, "R8", "urgent with 8 owed", ref_urgent, 0);
    check(ref_req == 1'b1, "R7", "request held without grant", ref_req, 1);
    check(dram_ras_n == 1'b1 && dram_cas_n == 1'b1, "R7", "strobes idle without grant",
          {dram_ras_n, dram_cas_n}, 3);

    wait (cyc >= s + (19 * EXP_INT) / 2);
    @(negedge clk); #1;
    check(ref_urgent == 1'b1, "R8", "urgent with 9 owed", ref_urgent, 1);
    check(n_done == done0, "R7", "no refresh while grant withheld", n_done - done0, 0);
    gnt_allow = 1'b1;

    wait (cyc >= s + (99 * EXP_INT) / 10);
    @(negedge clk); #1;
    check(n_done - done0 == 9, "R8", "owed refreshes drained", n_done - done0, 9);
    check(ref_urgent == 1'b0, "R8", "urgent cleared after drain", ref_urgent, 0);
    check(ref_req == 1'b0, "R8", "request idle after drain", ref_req, 0);

    wait (lp_falls.size() >= 10); #1;
    check(lp_falls[9] - lp_falls[8] == EXP_INT_LP, "R6", "low-power refresh spacing",
          lp_falls[9] - lp_falls[8], EXP_INT_LP);
    check(done_lp == 1'b1, "R2", "low-power instance initialised", done_lp, 1);
    check(we_bad == 0, "R9", "write enable low samples", we_bad, 0);
    end_run();
  end

endmodule